// File: doc/BRIEF.md
# Decode-Stage Dependency Interlock

This block sits beside the decode stage of a five-stage in-order pipeline (fetch, decode, execute, memory, writeback). Each cycle it looks at the source registers of the instruction waiting in decode. It compares them with the destination registers of the two older instructions still in flight in execute and memory. When a source would be read before its producer has written it back, the block holds the program counter and the fetch/decode register. It also turns the decode/execute slot into an empty bubble for that cycle, so older work keeps moving while the consumer waits.

The block keeps its own record of what occupies execute and memory. It fills that record from the decode-side fields and from the bubbles it inserts. A one-bit policy input chooses between two pipelines. With the interlock-only policy, any pending producer stalls the consumer, so the wait depends on how far apart the two instructions are. With the bypass policy, operands are forwarded, and only a load whose data is needed by the very next instruction causes a wait. A freeze input from elsewhere, such as a cache miss, holds the whole pipe. That freeze is passed through to the hold outputs and is not resolved here.

Top module: `hz_interlock`

## Requirements
- R1: After reset, no producer is tracked, so the first decoded instruction never stalls, whatever sources it names.
- R2: Under the interlock-only policy (`fwd_en`=0), a consumer directly behind its producer is held in decode for exactly 2 cycles. Three bubbles in a row never occur.
- R3: Under the interlock-only policy, a consumer one slot further from its producer (one instruction or empty slot in between) is held for exactly 1 cycle.
- R4: A producer that has reached writeback causes no stall, because the register file writes early in the cycle and reads late.
- R5: Under the bypass policy (`fwd_en`=1), a load followed directly by a dependent instruction stalls exactly 1 cycle. A non-load producer, or a load two slots ahead, causes no stall, and a bypass bubble is never followed by a second one.
- R6: A dependency stall raises `pc_hold`, `ifid_hold` and `idex_bubble` together. Without a stall or freeze, all three are low.
- R7: Register index 0 never creates a dependency, as a producer destination or as a consumer source.
- R8: A producer with its write enable low never creates a dependency.
- R9: A source whose use bit is low is ignored.
- R10: While `global_stall` is high, `pc_hold` and `ifid_hold` are high, `idex_bubble` is low, and the tracked execute/memory contents are frozen. The pending dependency therefore resumes with its full remaining stall count.
- R11: A decode slot with `id_valid` low never stalls, and it enters execute as an empty slot.
- R12: A match on either source (rs1 or rs2) is enough to stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fwd_en | input | 1 | 1 = bypass policy, 0 = interlock-only policy |
| global_stall | input | 1 | Freeze of the whole pipe from outside |
| id_valid | input | 1 | Decode slot holds a real instruction |
| id_rs1 | input | 5 | First source register index |
| id_rs1_use | input | 1 | First source is read |
| id_rs2 | input | 5 | Second source register index |
| id_rs2_use | input | 1 | Second source is read |
| id_rd | input | 5 | Destination register index |
| id_rd_we | input | 1 | Instruction writes its destination |
| id_is_load | input | 1 | Instruction is a memory load |
| pc_hold | output | 1 | Keep the program counter |
| ifid_hold | output | 1 | Keep the fetch/decode register |
| idex_bubble | output | 1 | Load an empty slot into decode/execute |

## Verification
The checker watches, on every cycle, how the three controls relate to each other. It confirms that a freeze never issues a bubble, that an invalid slot, unused sources or register 0 never stall, that bubbles never come three in a row, and that a bypass bubble is never followed by a second one. The exact stall lengths per distance and policy can only be shown by the bench's instruction sequences. The same holds for the frozen state resuming after a freeze and for the writeback case causing no wait, since each of these depends on a history of issued instructions.

// File: rtl/hz_pkg.sv
package hz_pkg;

    localparam int unsigned REG_AW      = 5;
    localparam int unsigned NUM_SRC     = 2;
    // execute and memory are the only stages whose result is not yet visible
    localparam int unsigned TRACK_DEPTH = 2;
    localparam int unsigned EX_SLOT     = 0;

    typedef logic [REG_AW-1:0] reg_id_t;

    typedef struct packed {
        logic    live;
        logic    wr;
        logic    ld;
        reg_id_t rd;
    } prod_tag_t;

    typedef struct packed {
        logic    use_it;
        reg_id_t id;
    } src_ref_t;

    typedef enum logic {
        POL_INTERLOCK = 1'b0,
        POL_BYPASS    = 1'b1
    } policy_e;

    localparam prod_tag_t EMPTY_TAG = '{live: 1'b0, wr: 1'b0, ld: 1'b0, rd: '0};

    function automatic logic writes_reg(prod_tag_t t);
        return t.live && t.wr && (t.rd != '0);
    endfunction

    function automatic logic src_hits(src_ref_t s, prod_tag_t t);
        return s.use_it && (s.id != '0) && writes_reg(t) && (s.id == t.rd);
    endfunction

endpackage

// File: rtl/hz_track.sv
module hz_track
    import hz_pkg::*;
#(
    parameter int unsigned DEPTH = TRACK_DEPTH
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  freeze,
    input  logic                  inject_bubble,
    input  prod_tag_t             id_tag,
    output prod_tag_t [DEPTH-1:0] stage_q
);

    for (genvar k = 0; k < DEPTH; k++) begin : g_stage
        prod_tag_t nxt;
        if (k == 0) begin : g_head
            always_comb nxt = inject_bubble ? EMPTY_TAG : id_tag;
        end else begin : g_body
            always_comb nxt = stage_q[k-1];
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                stage_q[k] <= EMPTY_TAG;
            end else if (!freeze) begin
                stage_q[k] <= nxt;
            end
        end
    end

endmodule

// File: rtl/hz_src_cmp.sv
module hz_src_cmp
    import hz_pkg::*;
#(
    parameter int unsigned DEPTH = TRACK_DEPTH
) (
    input  src_ref_t              src,
    input  prod_tag_t [DEPTH-1:0] stages,
    output logic      [DEPTH-1:0] hit
);

    for (genvar k = 0; k < DEPTH; k++) begin : g_cmp
        assign hit[k] = src_hits(src, stages[k]);
    end

endmodule

// File: rtl/hz_policy.sv
module hz_policy
    import hz_pkg::*;
#(
    parameter int unsigned DEPTH = TRACK_DEPTH,
    parameter int unsigned NSRC  = NUM_SRC
) (
    input  policy_e                          policy,
    input  logic                             slot_valid,
    input  prod_tag_t [DEPTH-1:0]            stages,
    input  logic      [NSRC-1:0][DEPTH-1:0]  hits,
    output logic                             data_stall
);

    logic [NSRC-1:0] any_hit;
    logic [NSRC-1:0] load_use;

    for (genvar s = 0; s < NSRC; s++) begin : g_src
        assign any_hit[s]  = |hits[s];
        assign load_use[s] = hits[s][EX_SLOT] && stages[EX_SLOT].ld;
    end

    always_comb begin
        data_stall = 1'b0;
        if (slot_valid) begin
            unique case (policy)
                POL_INTERLOCK: data_stall = |any_hit;
                POL_BYPASS:    data_stall = |load_use;
                default:       data_stall = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/hz_interlock.sv
module hz_interlock
    import hz_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              fwd_en,
    input  logic              global_stall,
    input  logic              id_valid,
    input  logic [REG_AW-1:0] id_rs1,
    input  logic              id_rs1_use,
    input  logic [REG_AW-1:0] id_rs2,
    input  logic              id_rs2_use,
    input  logic [REG_AW-1:0] id_rd,
    input  logic              id_rd_we,
    input  logic              id_is_load,
    output logic              pc_hold,
    output logic              ifid_hold,
    output logic              idex_bubble
);

    prod_tag_t                             id_tag;
    prod_tag_t [TRACK_DEPTH-1:0]           stages;
    src_ref_t  [NUM_SRC-1:0]               srcs;
    logic      [NUM_SRC-1:0][TRACK_DEPTH-1:0] hits;
    logic                                  data_stall;
    logic                                  inject;
    policy_e                               policy;

    assign policy = fwd_en ? POL_BYPASS : POL_INTERLOCK;

    assign id_tag = '{live: id_valid, wr: id_rd_we, ld: id_is_load, rd: id_rd};

    assign srcs[0] = '{use_it: id_rs1_use, id: id_rs1};
    assign srcs[1] = '{use_it: id_rs2_use, id: id_rs2};

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_cmp
        hz_src_cmp #(.DEPTH(TRACK_DEPTH)) u_cmp (
            .src    (srcs[s]),
            .stages (stages),
            .hit    (hits[s])
        );
    end

    hz_policy #(.DEPTH(TRACK_DEPTH), .NSRC(NUM_SRC)) u_policy (
        .policy     (policy),
        .slot_valid (id_valid),
        .stages     (stages),
        .hits       (hits),
        .data_stall (data_stall)
    );

    assign inject = data_stall && !global_stall;

    hz_track #(.DEPTH(TRACK_DEPTH)) u_track (
        .clk           (clk),
        .rst           (rst),
        .freeze        (global_stall),
        .inject_bubble (inject),
        .id_tag        (id_tag),
        .stage_q       (stages)
    );

    assign pc_hold     = data_stall || global_stall;
    assign ifid_hold   = data_stall || global_stall;
    assign idex_bubble = inject;

endmodule

// File: rtl/hz_interlock_chk.sv
module hz_interlock_chk
    import hz_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              fwd_en,
    input logic              global_stall,
    input logic              id_valid,
    input logic [REG_AW-1:0] id_rs1,
    input logic              id_rs1_use,
    input logic [REG_AW-1:0] id_rs2,
    input logic              id_rs2_use,
    input logic              pc_hold,
    input logic              ifid_hold,
    input logic              idex_bubble
);

    p_bubble_holds_r6: assert property (@(posedge clk) disable iff (rst)
        idex_bubble |-> (pc_hold && ifid_hold));

    p_freeze_r10: assert property (@(posedge clk) disable iff (rst)
        global_stall |-> (pc_hold && ifid_hold && !idex_bubble));

    p_empty_slot_r11: assert property (@(posedge clk) disable iff (rst)
        (!id_valid && !global_stall) |-> !pc_hold);

    p_no_sources_r9: assert property (@(posedge clk) disable iff (rst)
        (!id_rs1_use && !id_rs2_use) |-> !idex_bubble);

    p_zero_reg_r7: assert property (@(posedge clk) disable iff (rst)
        ((!id_rs1_use || id_rs1 == '0) && (!id_rs2_use || id_rs2 == '0)) |-> !idex_bubble);

    p_max_two_r2: assert property (@(posedge clk) disable iff (rst)
        (idex_bubble ##1 idex_bubble) |=> !idex_bubble);

    p_bypass_single_r5: assert property (@(posedge clk) disable iff (rst)
        ((fwd_en && idex_bubble) ##1 fwd_en) |-> !idex_bubble);

endmodule

bind hz_interlock hz_interlock_chk u_chk (.*);

// File: tb/hz_interlock_test.sv
module hz_interlock_test;

    logic       clk = 1'b0;
    logic       rst;
    logic       fwd_en, global_stall, id_valid;
    logic [4:0] id_rs1, id_rs2, id_rd;
    logic       id_rs1_use, id_rs2_use, id_rd_we, id_is_load;
    logic       pc_hold, ifid_hold, idex_bubble;

    int tests = 0;
    int fails = 0;

    always #5 clk = ~clk;

    hz_interlock uut (.*);

    typedef struct packed {
        logic       fwd;
        logic       vld;
        logic [4:0] rd;
        logic       we;
        logic       ld;
        logic [4:0] rs1;
        logic       u1;
        logic [4:0] rs2;
        logic       u2;
        logic [1:0] exp;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 54;
    localparam vec_t VEC [NV] = '{
        // R2: adjacent producer, interlock-only
        '{0,1, 2,1,0, 0,0, 0,0, 0, 2}, '{0,1, 9,0,0, 2,1, 0,0, 2, 2},
        '{0,1, 0,0,0, 0,0, 0,0, 0, 2}, '{0,1, 0,0,0, 0,0, 0,0, 0, 2}, '{0,1, 0,0,0, 0,0, 0,0, 0, 2},
        // R3: one instruction between
        '{0,1, 3,1,0, 0,0, 0,0, 0, 3}, '{0,1, 4,1,0, 5,1, 0,0, 0, 3}, '{0,1, 0,0,0, 0,0, 3,1, 1, 3},
        '{0,1, 0,0,0, 0,0, 0,0, 0, 3}, '{0,1, 0,0,0, 0,0, 0,0, 0, 3}, '{0,1, 0,0,0, 0,0, 0,0, 0, 3},
        // R4: producer in writeback
        '{0,1, 6,1,0, 0,0, 0,0, 0, 4}, '{0,1, 0,0,0, 0,0, 0,0, 0, 4}, '{0,1, 0,0,0, 0,0, 0,0, 0, 4},
        '{0,1, 0,0,0, 6,1, 0,0, 0, 4},
        '{0,1, 0,0,0, 0,0, 0,0, 0, 4}, '{0,1, 0,0,0, 0,0, 0,0, 0, 4}, '{0,1, 0,0,0, 0,0, 0,0, 0, 4},
        // R7: register 0
        '{0,1, 0,1,0, 0,0, 0,0, 0, 7}, '{0,1, 0,0,0, 0,1, 0,1, 0, 7},
        '{0,1, 0,0,0, 0,0, 0,0, 0, 7}, '{0,1, 0,0,0, 0,0, 0,0, 0, 7}, '{0,1, 0,0,0, 0,0, 0,0, 0, 7},
        // R8: producer without write
        '{0,1, 7,0,0, 0,0, 0,0, 0, 8}, '{0,1, 0,0,0, 7,1, 0,0, 0, 8},
        '{0,1, 0,0,0, 0,0, 0,0, 0, 8}, '{0,1, 0,0,0, 0,0, 0,0, 0, 8}, '{0,1, 0,0,0, 0,0, 0,0, 0, 8},
        // R9: unused source field matches
        '{0,1, 8,1,0, 0,0, 0,0, 0, 9}, '{0,1, 0,0,0, 8,0, 1,1, 0, 9},
        '{0,1, 0,0,0, 0,0, 0,0, 0, 9}, '{0,1, 0,0,0, 0,0, 0,0, 0, 9}, '{0,1, 0,0,0, 0,0, 0,0, 0, 9},
        // R12: match on second source only
        '{0,1,10,1,0, 0,0, 0,0, 0,12}, '{0,1, 0,0,0,11,1,10,1, 2,12},
        '{0,1, 0,0,0, 0,0, 0,0, 0,12}, '{0,1, 0,0,0, 0,0, 0,0, 0,12}, '{0,1, 0,0,0, 0,0, 0,0, 0,12},
        // R5: bypass policy
        '{1,1,12,1,1, 0,0, 0,0, 0, 5}, '{1,1, 0,0,0,12,1, 0,0, 1, 5},
        '{1,1,13,1,0, 0,0, 0,0, 0, 5}, '{1,1, 0,0,0, 0,0,13,1, 0, 5},
        '{1,1,14,1,1, 0,0, 0,0, 0, 5}, '{1,1, 0,0,0, 0,0, 0,0, 0, 5}, '{1,1, 0,0,0,14,1, 0,0, 0, 5},
        '{1,1, 0,0,0, 0,0, 0,0, 0, 5}, '{1,1, 0,0,0, 0,0, 0,0, 0, 5}, '{1,1, 0,0,0, 0,0, 0,0, 0, 5},
        // R11: empty decode slot, then a real consumer one slot behind (R3 distance)
        '{0,1,15,1,0, 0,0, 0,0, 0,11}, '{0,0, 0,0,0,15,1,15,1, 0,11}, '{0,1, 0,0,0,15,1, 0,0, 1,11},
        '{0,1, 0,0,0, 0,0, 0,0, 0,11}, '{0,1, 0,0,0, 0,0, 0,0, 0,11}, '{0,1, 0,0,0, 0,0, 0,0, 0,11}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic drive(input vec_t v);
        fwd_en     = v.fwd;
        id_valid   = v.vld;
        id_rd      = v.rd;
        id_rd_we   = v.we;
        id_is_load = v.ld;
        id_rs1     = v.rs1;
        id_rs1_use = v.u1;
        id_rs2     = v.rs2;
        id_rs2_use = v.u2;
    endtask

    // present one instruction and count the cycles it is held in decode
    task automatic issue(input vec_t v, output int stalls);
        bit done = 0;
        drive(v);
        stalls = 0;
        while (!done) begin
            @(negedge clk);
            if (pc_hold && stalls < 8) begin
                // R6: the three controls move together
                check(ifid_hold && idex_bubble, "R6", {ifid_hold, idex_bubble}, 3);
                stalls++;
            end else begin
                check(!ifid_hold && !idex_bubble, "R6", {ifid_hold, idex_bubble}, 0);
                done = 1;
            end
            @(posedge clk);
            #1;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got 1 expected 0");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int st;
        vec_t c;
        rst = 1'b1;
        global_stall = 1'b0;
        drive('0);
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;

        // R1: nothing tracked after reset
        c = '{0,1, 0,0,0, 5,1, 9,1, 0, 1};
        drive(c);
        @(negedge clk);
        check(!pc_hold && !ifid_hold && !idex_bubble, "R1", pc_hold, 0);
        @(posedge clk);
        #1;
        drive('{0,1, 0,0,0, 0,0, 0,0, 0, 1});
        repeat (2) @(posedge clk);
        #1;

        for (int i = 0; i < NV; i++) begin
            issue(VEC[i], st);
            if (st != int'(VEC[i].exp)) begin
                tests++;
                fails++;
                $display("FAIL R%0d: vector %0d stall cycles got %0d expected %0d",
                         VEC[i].req, i, st, VEC[i].exp);
            end else begin
                tests++;
            end
        end

        // R10: freeze with a dependency pending keeps state; full 2-cycle wait follows
        issue('{0,1,20,1,0, 0,0, 0,0, 0,10}, st);
        drive('{0,1, 0,0,0,20,1, 0,0, 2,10});
        global_stall = 1'b1;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            check(pc_hold && ifid_hold && !idex_bubble, "R10",
                  {pc_hold, ifid_hold, idex_bubble}, 6);
            @(posedge clk);
            #1;
        end
        global_stall = 1'b0;
        issue('{0,1, 0,0,0,20,1, 0,0, 2,10}, st);
        check(st == 2, "R10", st, 2);

        // R10: freeze without dependency still holds front end, no bubble
        drive('{0,1, 0,0,0, 0,0, 0,0, 0,10});
        repeat (3) @(posedge clk);
        #1;
        global_stall = 1'b1;
        @(negedge clk);
        check(pc_hold && ifid_hold && !idex_bubble, "R10", {pc_hold, ifid_hold, idex_bubble}, 6);
        @(posedge clk);
        #1;
        global_stall = 1'b0;
        @(negedge clk);
        check(!pc_hold, "R10", pc_hold, 0);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule